// File: doc/BRIEF.md
# Grouped Peripheral Interrupt Sub-Controller

This block is a second-level interrupt controller with 32 peripheral request inputs. It keeps a 32-bit pending-status register and a 32-bit enable mask. Both registers are reached through a small read/write port whose select line picks one of the two.

The pending bits that are enabled are folded into three group request lines, which feed a top-level aggregator:

| Group | Line | Sources |
|---|---|---|
| Audio | `grp_irq_o[0]` | positions 0 to 7 |
| Miscellaneous | `grp_irq_o[1]` | positions 8 to 15: real-time clock, keyboard, keyboard poll, mouse, mouse poll, three timers |
| Peripheral I/O | `grp_irq_o[2]` | positions 16 to 31: a parallel port and two serial ports |

Most sources are level-sensitive, so their status bit mirrors the input. Three positions are different: 16, 22 and 28 capture a rising edge. Each of these stays pending until software writes the status register back with that bit cleared.

Beside the group lines, the block reports the lowest-numbered enabled pending source. The top-level handler uses this to find the device without scanning the register. The group lines and the reported index are registered. They move on the same clock edge as the status and mask registers.

Top module: `grouped_irq_ctrl`

## Requirements
- R1: While reset is held and directly after it, the status register, the mask register, all three group lines and `pend_valid_o` read zero.
- R2: A level-sensitive status bit equals the value its input had at the previous rising clock edge.
- R3: A write to the status register (`reg_sel_i`=0) does not change any level-sensitive bit.
- R4: Positions 16, 22 and 28 set on a rising edge of their input and stay set after the input falls.
- R5: A status write loads the written value into positions 16, 22 and 28. Writing 0 clears them and writing 1 sets them.
- R6: A rising edge on an edge position in the same cycle as a status write of 0 to that position leaves the bit set.
- R7: A mask write (`reg_sel_i`=1) stores the full 32-bit word, and a read with `reg_sel_i`=1 returns it.
- R8: `grp_irq_o[0]` is the OR of status AND mask over bits 0 to 7. `grp_irq_o[1]` covers bits 8 to 15. `grp_irq_o[2]` covers bits 16 to 31.
- R9: `pend_valid_o` is 1 when any bit of status AND mask is 1. `pend_idx_o` then gives the bit number of the lowest such bit. When nothing is pending, `pend_idx_o` is 0.
- R10: The group lines and the reported index change on the first rising edge after an input or mask change, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Peripheral request inputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 status, 1 mask |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| grp_irq_o | output | 3 | Group requests: bit 0 audio, bit 1 miscellaneous, bit 2 peripheral I/O |
| pend_valid_o | output | 1 | Some enabled source is pending |
| pend_idx_o | output | 5 | Lowest enabled pending bit number |

## Verification
A wrong bit in the status or mask register becomes visible at the port one clock later. It shows as a group line that disagrees with the read-back of the two registers, or as a reported index that differs from the lowest set bit of their AND.

A lost edge latch shows the other way round. The status read-back drops to zero after the input falls, even though no clearing write was made. A clear that wins over a rising edge in the same cycle is caught by reading status on the cycle after the collision.

// File: rtl/pgic_pkg.sv
package pgic_pkg;
  localparam int unsigned SRC_N = 32;
  localparam int unsigned GRP_N = 3;
  localparam logic [SRC_N-1:0] EDGE_POS = 32'h1041_0000;  // positions 28, 22, 16
  typedef enum logic [1:0] {GRP_AUDIO = 2'd0, GRP_MISC = 2'd1, GRP_PIO = 2'd2} grp_e;
  typedef enum logic {SEL_STATUS = 1'b0, SEL_MASK = 1'b1} reg_sel_e;
endpackage

// File: rtl/pgic_status.sv
module pgic_status #(
  parameter int unsigned SRC_N = 32,
  parameter logic [SRC_N-1:0] EDGE_POS = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] src_i,
  input  logic             wr_i,
  input  logic [SRC_N-1:0] wdata_i,
  output logic [SRC_N-1:0] st_d_o,
  output logic [SRC_N-1:0] st_q_o
);
  logic [SRC_N-1:0] prev_q, st_q, rise, base;
  logic             ok_q;

  assign rise = src_i & ~prev_q & EDGE_POS;

  always_comb begin
    base   = wr_i ? wdata_i : st_q;
    // edge positions: held or written, a new edge always wins
    st_d_o = (EDGE_POS & (base | rise)) | (~EDGE_POS & src_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      st_q   <= '0;
      ok_q   <= 1'b0;
    end else begin
      prev_q <= src_i;
      st_q   <= st_d_o;
      ok_q   <= 1'b1;
    end
  end

  assign st_q_o = st_q;

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_q |-> ((st_q & ~EDGE_POS) == ($past(src_i) & ~EDGE_POS))); // R2

  for (genvar b = 0; b < SRC_N; b++) begin : g_edge_chk
    if (EDGE_POS[b]) begin : g_on
      AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ok_q && $past(st_q[b]) && !$past(wr_i)) |-> st_q[b]); // R4
      AST_EDGE_RISE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ok_q && $past(src_i[b] && !prev_q[b])) |-> st_q[b]); // R6
      AST_EDGE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ok_q && $past(wr_i && !wdata_i[b] && !(src_i[b] && !prev_q[b]))) |-> !st_q[b]); // R5
    end
  end
endmodule

// File: rtl/pgic_fold.sv
module pgic_fold #(
  parameter int unsigned SRC_N   = 32,
  parameter int unsigned GRP_N   = 3,
  parameter int unsigned MISC_LO = 8,
  parameter int unsigned PIO_LO  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] live_d_i,
  output logic [GRP_N-1:0] grp_o
);
  logic [GRP_N-1:0] grp_d, grp_q;

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    localparam int unsigned LO = (g == 0) ? 0 : (g == 1) ? MISC_LO : PIO_LO;
    localparam int unsigned HI = (g == 0) ? MISC_LO - 1 : (g == 1) ? PIO_LO - 1 : SRC_N - 1;
    assign grp_d[g] = |live_d_i[HI:LO];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) grp_q <= '0;
    else         grp_q <= grp_d;
  end

  assign grp_o = grp_q;
endmodule

// File: rtl/pgic_pick.sv
module pgic_pick #(
  parameter int unsigned SRC_N = 32,
  parameter int unsigned IDX_W = $clog2(SRC_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] req_d_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             valid_d, valid_q;
  logic [IDX_W-1:0] idx_d, idx_q;

  always_comb begin
    valid_d = |req_d_i;
    idx_d   = '0;
    // walk downward so the lowest set bit is written last
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (req_d_i[i]) idx_d = IDX_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      valid_q <= valid_d;
      idx_q   <= idx_d;
    end
  end

  assign valid_o = valid_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/grouped_irq_ctrl.sv
module grouped_irq_ctrl
  import pgic_pkg::*;
#(
  parameter int unsigned SRC_N   = pgic_pkg::SRC_N,
  parameter int unsigned MISC_LO = 8,
  parameter int unsigned PIO_LO  = 16,
  parameter logic [SRC_N-1:0] EDGE_POS = pgic_pkg::EDGE_POS,
  localparam int unsigned IDX_W  = $clog2(SRC_N),
  localparam int unsigned GRP_N  = pgic_pkg::GRP_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      src_i,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic [2:0]       grp_irq_o,
  output logic             pend_valid_o,
  output logic [4:0]       pend_idx_o
);
  logic [SRC_N-1:0] st_d, st_q, mask_d, mask_q, live_d, live_q;
  logic             st_wr, mask_wr;

  assign st_wr   = reg_we_i && (reg_sel_e'(reg_sel_i) == SEL_STATUS);
  assign mask_wr = reg_we_i && (reg_sel_e'(reg_sel_i) == SEL_MASK);

  pgic_status #(.SRC_N(SRC_N), .EDGE_POS(EDGE_POS)) u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (src_i),
    .wr_i    (st_wr),
    .wdata_i (reg_wdata_i),
    .st_d_o  (st_d),
    .st_q_o  (st_q)
  );

  assign mask_d = mask_wr ? reg_wdata_i : mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  // outputs are built from next-state values so they track the registers
  assign live_d = st_d & mask_d;
  assign live_q = st_q & mask_q;

  pgic_fold #(.SRC_N(SRC_N), .GRP_N(GRP_N), .MISC_LO(MISC_LO), .PIO_LO(PIO_LO)) u_fold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .live_d_i (live_d),
    .grp_o    (grp_irq_o)
  );

  pgic_pick #(.SRC_N(SRC_N), .IDX_W(IDX_W)) u_pick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_d_i (live_d),
    .valid_o (pend_valid_o),
    .idx_o   (pend_idx_o)
  );

  assign reg_rdata_o = (reg_sel_e'(reg_sel_i) == SEL_MASK) ? mask_q : st_q;

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_QUIET: assert (grp_irq_o == '0 && !pend_valid_o && st_q == '0 && mask_q == '0); // R1
  end

  AST_MASK_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mask_wr) |-> (mask_q == $past(reg_wdata_i))); // R7
  AST_GRP_AUDIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_irq_o[GRP_AUDIO] == (|live_q[MISC_LO-1:0])); // R8
  AST_GRP_MISC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_irq_o[GRP_MISC] == (|live_q[PIO_LO-1:MISC_LO])); // R8
  AST_GRP_PIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_irq_o[GRP_PIO] == (|live_q[SRC_N-1:PIO_LO])); // R8
  AST_PICK_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_valid_o |-> live_q[pend_idx_o]); // R9
  AST_PICK_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_valid_o |-> ((live_q & ((SRC_N'(1) << pend_idx_o) - SRC_N'(1))) == '0)); // R9
  AST_PICK_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_valid_o |-> (live_q == '0 && pend_idx_o == '0)); // R9
endmodule

// File: tb/sim_grouped_irq_ctrl.sv
module sim_grouped_irq_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic        reg_we_i = 1'b0;
  logic        reg_sel_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [2:0]  grp_irq_o;
  logic        pend_valid_o;
  logic [4:0]  pend_idx_o;

  int nchk = 0;
  int nfail = 0;

  always #5 clk_i = ~clk_i;

  grouped_irq_ctrl u0 (
    .clk_i, .rst_ni, .src_i, .reg_we_i, .reg_sel_i, .reg_wdata_i,
    .reg_rdata_o, .grp_irq_o, .pend_valid_o, .pend_idx_o
  );

  // level-only vectors: inputs, mask, expected groups, valid, index
  localparam int NV = 9;
  localparam logic [31:0] V_SRC [NV] = '{32'h0000_0001, 32'h0000_0300, 32'h8000_0000,
    32'h8000_0300, 32'h0000_00F0, 32'h0220_8080, 32'h0220_8080, 32'hEFBE_FFFF, 32'h0000_4000};
  localparam logic [31:0] V_MSK [NV] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
    32'h0000_0200, 32'h0000_0F00, 32'hFFFF_FFFF, 32'hFFFF_0000, 32'h0000_0000, 32'h0000_4000};
  localparam logic [2:0] V_GRP [NV] = '{3'b001, 3'b010, 3'b100, 3'b010, 3'b000, 3'b111, 3'b100, 3'b000, 3'b010};
  localparam logic V_VLD [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic [4:0] V_IDX [NV] = '{5'd0, 5'd8, 5'd31, 5'd9, 5'd0, 5'd7, 5'd21, 5'd0, 5'd14};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    reg_sel_i = sel;
    #1 v = reg_rdata_o;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic outs(input string req, input logic [2:0] g, input logic v, input logic [4:0] i);
    chk(req, {29'd0, grp_irq_o}, {29'd0, g});
    chk(req, {31'd0, pend_valid_o}, {31'd0, v});
    chk(req, {27'd0, pend_idx_o}, {27'd0, i});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    // R1: quiet during reset
    rd(1'b0, v); chk("R1 status in reset", v, 32'h0);
    rd(1'b1, v); chk("R1 mask in reset", v, 32'h0);
    outs("R1 outputs in reset", 3'b000, 1'b0, 5'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    rd(1'b0, v); chk("R1 status after reset", v, 32'h0);
    outs("R1 outputs after reset", 3'b000, 1'b0, 5'd0);

    // R8 R9 R10: vector table, outputs one edge after the change
    for (int k = 0; k < NV; k++) begin
      @(negedge clk_i);
      src_i = V_SRC[k]; reg_we_i = 1'b1; reg_sel_i = 1'b1; reg_wdata_i = V_MSK[k];
      @(negedge clk_i);
      reg_we_i = 1'b0;
      outs("R8 R9 vector", V_GRP[k], V_VLD[k], V_IDX[k]);
      rd(1'b0, v); chk("R2 level mirror", v, V_SRC[k]);
    end

    // R10: nothing moves before the edge
    @(negedge clk_i); src_i = '0;
    wr(1'b1, 32'hFFFF_FFFF);
    @(negedge clk_i); src_i = 32'h0000_0004;
    #1 outs("R10 before edge", 3'b000, 1'b0, 5'd0);
    @(negedge clk_i);
    outs("R10 after edge", 3'b001, 1'b1, 5'd2);
    src_i = '0;
    @(negedge clk_i);

    // R4: edge latch at 16 survives input fall
    @(negedge clk_i); src_i = 32'h0001_0000;
    @(negedge clk_i); src_i = '0;
    @(negedge clk_i);
    rd(1'b0, v); chk("R4 edge held", v, 32'h0001_0000);
    outs("R4 edge outputs", 3'b100, 1'b1, 5'd16);

    // R5: write 0 clears, write 1 sets
    wr(1'b0, 32'h0);
    rd(1'b0, v); chk("R5 clear", v, 32'h0);
    outs("R5 cleared outputs", 3'b000, 1'b0, 5'd0);
    wr(1'b0, 32'h1000_0000);
    rd(1'b0, v); chk("R5 set by write", v, 32'h1000_0000);
    outs("R5 set outputs", 3'b100, 1'b1, 5'd28);
    wr(1'b0, 32'h0);

    // R6: rising edge together with clearing write
    @(negedge clk_i);
    src_i = 32'h0040_0000; reg_we_i = 1'b1; reg_sel_i = 1'b0; reg_wdata_i = 32'h0;
    @(negedge clk_i); reg_we_i = 1'b0;
    rd(1'b0, v); chk("R6 edge beats clear", v, 32'h0040_0000);
    wr(1'b0, 32'h0);
    rd(1'b0, v); chk("R5 clear with input still high", v, 32'h0);
    src_i = '0;

    // R3: level bits ignore status writes
    @(negedge clk_i); src_i = 32'h0000_0008;
    wr(1'b0, 32'h0000_0020);
    rd(1'b0, v); chk("R3 level write ignored", v, 32'h0000_0008);

    // R7: mask store and readback, groups follow new mask
    wr(1'b1, 32'h0000_A5A5);
    rd(1'b1, v); chk("R7 mask readback", v, 32'h0000_A5A5);
    outs("R8 masked out", 3'b000, 1'b0, 5'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule